// File: doc/BRIEF.md
# Lockable System Control Register Bank

This block is the register bank of a processor core module. It sits behind a simple word-addressed bus. A write strobe, a word address and a 32-bit write word are sampled on the clock edge, and read data is presented combinationally for whatever address is on the bus. The bank holds a constant identification word and a constant status word. It also holds two oscillator settings protected by a 16-bit unlock key, a control word, SDRAM configuration and init words, and two flag words that are changed through separate set and clear addresses. A free-running count advances at a fixed reference rate derived from the bus clock.

The control word drives three outputs. One is an LED. One tells the memory system whether the boot flash is mapped at address zero. The third is a one-cycle reset request raised during the write that asks for it. A read-only byte window gives software access to a memory-module parameter table that is computed at elaboration time. The SDRAM word picks up a size code from a memory-size parameter at reset.

Top module: `sysctl_regbank`

## Requirements
- R1: Word 0 reads 0x411A3001, word 4 reads 0x00100000 and word 1 reads 0. Word addresses 16 to 63 and from 128 up read zero, and writes to them change nothing readable.
- R2: A write to word 5 stores bits 15:0 of the write word. A read of word 5 returns the stored value in bits 15:0, with bit 16 set exactly when the stored value equals the key 0xA05F, and bits 31:17 zero.
- R3: Writes to word 2 (oscillator) and word 7 (auxiliary oscillator) store the full word only while the word-5 value equals 0xA05F. At any other time they leave the register unchanged.
- R4: Word 3 keeps only write bits 0 and 2, and reads back with every other bit zero, including bit 3. led_o equals stored bit 0, and flash_at_zero_o equals the inverse of stored bit 2.
- R5: reset_req_o is high during exactly those cycles in which wr_i is high, the word address is 3 and write bit 3 is set. It is low otherwise.
- R6: Writing word 12 ORs the write word into the flags register, and writing word 13 clears the bits set in the write word. Words 14 and 15 do the same for the non-volatile flags register. Words 12 and 14 read the current values, and words 13 and 15 read zero.
- R7: Word 8 (SDRAM) and word 9 (init) store and return any full 32-bit write word.
- R8: After reset the registers hold the following values:
  - word 2: 0x01000048
  - word 7: 0x0007FEFF
  - word 8: 0x00011122 ORed with the size code. The size code is 0x10 for MEM_MB ≥ 256, 0x0C for ≥ 128, 0x08 for ≥ 64, 0x04 for ≥ 32, and 0 below that, so the default of 128 gives 0x0001112E.
  - word 9: 0x00000112
  - words 3, 5, 12 and 14: 0
- R9: Word 10 returns a 32-bit count that advances by REF_HZ/CLK_HZ per clock (24/50 by default) and never by more than one per clock. Over T clocks it advances by floor or ceil of T·REF_HZ/CLK_HZ.
- R10: Word addresses 64 to 95 (byte offsets 0x100–0x17F) return, zero-extended, byte 64+(word−64) of the parameter table. That table holds the ASCII text "GENERIC-MEM" at indices 73 to 83 and zero elsewhere. Word addresses 96 to 127 read zero, and writes to the window change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and register clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_i | input | 1 | Write strobe, sampled on the rising edge |
| waddr_i | input | AW | Word address (byte offset divided by 4) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for waddr_i |
| led_o | output | 1 | LED drive from control bit 0 |
| flash_at_zero_o | output | 1 | High while boot flash is mapped at address zero |
| reset_req_o | output | 1 | Reset request, high during a qualifying control write |

## Verification
The oscillator registers are driven with a random mix of lock writes, some carrying the key and some random values, interleaved with oscillator writes. This separates a guard that checks the whole key from one that checks only part of it, or checks a stale value. The flag pairs get random set and clear masks that overlap earlier ones, so an OR or AND-NOT model tells a proper set/clear apart from a plain overwrite. Directed cases then cover the following:
- control writes with bits 1, 3 and higher set, which show what is kept and when the reset pulse fires;
- the edges of the table window and of its zero upper half;
- a count interval long enough to show the 24/50 rate exactly.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   localparam logic [31:0] ID_WORD    = 32'h411A3001;
   localparam logic [31:0] STAT_WORD  = 32'h00100000;
   localparam logic [31:0] OSC_INIT   = 32'h01000048;
   localparam logic [31:0] AUX_INIT   = 32'h0007FEFF;
   localparam logic [31:0] SDRAM_BASE = 32'h00011122;
   localparam logic [31:0] INIT_INIT  = 32'h00000112;

   // register word map inside the first sixteen words
   typedef enum logic [3:0] {
      RW_IDENT   = 4'd0,
      RW_PROC    = 4'd1,
      RW_OSC     = 4'd2,
      RW_CTRL    = 4'd3,
      RW_STAT    = 4'd4,
      RW_LOCK    = 4'd5,
      RW_AUXOSC  = 4'd7,
      RW_SDRAM   = 4'd8,
      RW_INIT    = 4'd9,
      RW_REFCNT  = 4'd10,
      RW_FLG_SET = 4'd12,
      RW_FLG_CLR = 4'd13,
      RW_NVF_SET = 4'd14,
      RW_NVF_CLR = 4'd15
   } reg_word_e;

   // control word bit positions
   localparam int CTL_LED   = 0;
   localparam int CTL_REMAP = 2;
   localparam int CTL_RESET = 3;

   // parameter table: text tag placed at a fixed index
   localparam int unsigned TBL_TAG_FIRST = 73;
   localparam int unsigned TBL_TAG_LEN   = 11;
   localparam logic [8*TBL_TAG_LEN-1:0] TBL_TAG = "GENERIC-MEM";

   function automatic logic [31:0] mem_size_code(int unsigned mb);
      if (mb >= 256)     return 32'h10;
      else if (mb >= 128) return 32'h0C;
      else if (mb >= 64)  return 32'h08;
      else if (mb >= 32)  return 32'h04;
      else                return 32'h00;
   endfunction

   function automatic logic [7:0] table_byte(int unsigned idx);
      if (idx >= TBL_TAG_FIRST && idx < TBL_TAG_FIRST + TBL_TAG_LEN)
         return TBL_TAG[8*(TBL_TAG_LEN-1-(idx-TBL_TAG_FIRST)) +: 8];
      else
         return 8'h00;
   endfunction

endpackage

// File: rtl/sysctl_keyguard.sv
module sysctl_keyguard #(
   parameter logic [15:0] KEY      = 16'hA05F,
   parameter logic [31:0] OSC_RST  = 32'h0,
   parameter logic [31:0] AUX_RST  = 32'h0
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        lock_we_i,
   input  logic        osc_we_i,
   input  logic        aux_we_i,
   input  logic [31:0] wdata_i,
   output logic [15:0] lock_o,
   output logic        open_o,
   output logic [31:0] osc_o,
   output logic [31:0] aux_o
);
   logic [15:0] lock_q;
   logic [31:0] osc_q, aux_q;

   assign open_o = (lock_q == KEY);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         lock_q <= '0;
         osc_q  <= OSC_RST;
         aux_q  <= AUX_RST;
      end else begin
         if (lock_we_i)           lock_q <= wdata_i[15:0];
         if (osc_we_i && open_o)  osc_q  <= wdata_i;
         if (aux_we_i && open_o)  aux_q  <= wdata_i;
      end
   end

   assign lock_o = lock_q;
   assign osc_o  = osc_q;
   assign aux_o  = aux_q;
endmodule

// File: rtl/sysctl_flagpair.sv
module sysctl_flagpair #(
   parameter int DW = 32
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          set_we_i,
   input  logic          clr_we_i,
   input  logic [DW-1:0] mask_i,
   output logic [DW-1:0] q_o
);
   logic [DW-1:0] q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)       q <= '0;
      else if (set_we_i) q <= q | mask_i;
      else if (clr_we_i) q <= q & ~mask_i;
   end

   assign q_o = q;
endmodule

// File: rtl/sysctl_refcnt.sv
module sysctl_refcnt #(
   parameter int unsigned CLK_HZ = 50_000_000,
   parameter int unsigned REF_HZ = 24_000_000,
   parameter int          CW     = 32
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   output logic [CW-1:0] count_o
);
   logic [CW-1:0] cnt_q;

   generate
      if (REF_HZ == CLK_HZ) begin : g_direct
         always_ff @(posedge clk_i) begin
            if (!rst_ni) cnt_q <= '0;
            else         cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_frac
         localparam int ACC_W = $clog2(CLK_HZ + REF_HZ + 1);
         localparam logic [ACC_W-1:0] STEP = ACC_W'(REF_HZ);
         localparam logic [ACC_W-1:0] WRAP = ACC_W'(CLK_HZ);
         logic [ACC_W-1:0] acc_q, acc_sum;

         assign acc_sum = acc_q + STEP;

         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               acc_q <= '0;
               cnt_q <= '0;
            end else if (acc_sum >= WRAP) begin
               acc_q <= acc_sum - WRAP;
               cnt_q <= cnt_q + 1'b1;
            end else begin
               acc_q <= acc_sum;
            end
         end
      end
   endgenerate

   assign count_o = cnt_q;
endmodule

// File: rtl/sysctl_param_rom.sv
module sysctl_param_rom #(
   parameter int unsigned BASE_IDX = 64,
   parameter int          IW       = 5
) (
   input  logic [IW-1:0] idx_i,
   output logic [7:0]    byte_o
);
   import sysctl_pkg::*;
   localparam int DEPTH = 1 << IW;

   logic [DEPTH-1:0][7:0] rom;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_ent
         assign rom[i] = table_byte(BASE_IDX + i);
      end
   endgenerate

   assign byte_o = rom[idx_i];
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank #(
   parameter int          AW     = 10,
   parameter int unsigned MEM_MB = 128,
   parameter int unsigned CLK_HZ = 50_000_000,
   parameter int unsigned REF_HZ = 24_000_000,
   parameter logic [15:0] KEY    = 16'hA05F
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          wr_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [31:0]   wdata_i,
   output logic [31:0]   rdata_o,
   output logic          led_o,
   output logic          flash_at_zero_o,
   output logic          reset_req_o
);
   import sysctl_pkg::*;

   localparam int          WIN_IW     = 5;
   localparam int unsigned WIN_BASE   = 64;
   localparam logic [31:0] SDRAM_RST  = SDRAM_BASE | mem_size_code(MEM_MB);

   initial begin
      assert (AW >= 7) else $error("AW too small for the table window");
      assert (REF_HZ > 0 && REF_HZ <= CLK_HZ) else $error("REF_HZ must lie in 1..CLK_HZ");
   end

   // address decode
   logic      reg_hit, win_hit, win_lo;
   reg_word_e word;

   assign reg_hit = (waddr_i[AW-1:4] == '0);
   assign win_hit = (waddr_i[AW-1:6] == (AW-6)'(1));
   assign win_lo  = ~waddr_i[5];
   assign word    = reg_word_e'(waddr_i[3:0]);

   function automatic logic hit(input reg_word_e w);
      return wr_i && reg_hit && (word == w);
   endfunction

   // oscillators behind the key
   logic [15:0] lock_w;
   logic        open_w;
   logic [31:0] osc_w, aux_w;

   sysctl_keyguard #(
      .KEY(KEY), .OSC_RST(OSC_INIT), .AUX_RST(AUX_INIT)
   ) u_key (
      .clk_i, .rst_ni,
      .lock_we_i (hit(RW_LOCK)),
      .osc_we_i  (hit(RW_OSC)),
      .aux_we_i  (hit(RW_AUXOSC)),
      .wdata_i,
      .lock_o    (lock_w),
      .open_o    (open_w),
      .osc_o     (osc_w),
      .aux_o     (aux_w)
   );

   // set/clear flag pairs: pair g lives at words 12+2g (set) and 13+2g (clear)
   logic [1:0][31:0] flag_w;
   logic [31:0]      flag0_w;

   generate
      for (genvar g = 0; g < 2; g++) begin : g_flag
         localparam reg_word_e SET_W = reg_word_e'(4'(12 + 2*g));
         localparam reg_word_e CLR_W = reg_word_e'(4'(13 + 2*g));
         sysctl_flagpair #(.DW(32)) u_pair (
            .clk_i, .rst_ni,
            .set_we_i (hit(SET_W)),
            .clr_we_i (hit(CLR_W)),
            .mask_i   (wdata_i),
            .q_o      (flag_w[g])
         );
      end
   endgenerate
   assign flag0_w = flag_w[0];

   // reference counter
   logic [31:0] cnt_w;
   sysctl_refcnt #(.CLK_HZ(CLK_HZ), .REF_HZ(REF_HZ), .CW(32)) u_cnt (
      .clk_i, .rst_ni, .count_o(cnt_w)
   );

   // parameter table window
   logic [7:0] tbl_byte;
   sysctl_param_rom #(.BASE_IDX(WIN_BASE), .IW(WIN_IW)) u_rom (
      .idx_i  (waddr_i[WIN_IW-1:0]),
      .byte_o (tbl_byte)
   );

   // plain storage: control, SDRAM, init
   logic        led_q, remap_q;
   logic [31:0] sdram_q, init_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         led_q   <= 1'b0;
         remap_q <= 1'b0;
         sdram_q <= SDRAM_RST;
         init_q  <= INIT_INIT;
      end else begin
         if (hit(RW_CTRL)) begin
            led_q   <= wdata_i[CTL_LED];
            remap_q <= wdata_i[CTL_REMAP];
         end
         if (hit(RW_SDRAM)) sdram_q <= wdata_i;
         if (hit(RW_INIT))  init_q  <= wdata_i;
      end
   end

   assign led_o           = led_q;
   assign flash_at_zero_o = ~remap_q;
   assign reset_req_o     = hit(RW_CTRL) && wdata_i[CTL_RESET];

   // read mux
   always_comb begin
      rdata_o = '0;
      if (win_hit) begin
         if (win_lo) rdata_o = {24'h0, tbl_byte};
      end else if (reg_hit) begin
         case (word)
            RW_IDENT:   rdata_o = ID_WORD;
            RW_OSC:     rdata_o = osc_w;
            RW_CTRL:    rdata_o = {29'h0, remap_q, 1'b0, led_q};
            RW_STAT:    rdata_o = STAT_WORD;
            RW_LOCK:    rdata_o = {15'h0, open_w, lock_w};
            RW_AUXOSC:  rdata_o = aux_w;
            RW_SDRAM:   rdata_o = sdram_q;
            RW_INIT:    rdata_o = init_q;
            RW_REFCNT:  rdata_o = cnt_w;
            RW_FLG_SET: rdata_o = flag_w[0];
            RW_NVF_SET: rdata_o = flag_w[1];
            default:    rdata_o = '0;
         endcase
      end
   end
endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk #(
   parameter int          AW  = 10,
   parameter logic [15:0] KEY = 16'hA05F
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          wr_i,
   input logic [AW-1:0] waddr_i,
   input logic [31:0]   wdata_i,
   input logic [31:0]   rdata_o,
   input logic          led_o,
   input logic          reset_req_o,
   input logic [15:0]   lock_w,
   input logic [31:0]   osc_w,
   input logic [31:0]   flag0_w,
   input logic [31:0]   cnt_w
);
   AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (waddr_i >= AW'(128) || (waddr_i >= AW'(16) && waddr_i < AW'(64))) |-> rdata_o == 32'h0); // R1
   AST_LOCK_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (waddr_i == AW'(5)) |-> (rdata_o[16] == (rdata_o[15:0] == KEY)) && rdata_o[31:17] == '0); // R2
   AST_OSC_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && waddr_i == AW'(2) && lock_w != KEY) |=> $stable(osc_w)); // R3
   AST_CTRL_B3_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (waddr_i == AW'(3)) |-> !rdata_o[3]); // R4
   AST_LED_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && waddr_i == AW'(3)) |=> led_o == $past(wdata_i[0])); // R4
   AST_RESET_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reset_req_o |-> wr_i && waddr_i == AW'(3)); // R5
   AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && waddr_i == AW'(12)) |=> (flag0_w & $past(wdata_i)) == $past(wdata_i)); // R6
   AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_w - $past(cnt_w)) <= 32'd1); // R9
   AST_WIN_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (waddr_i >= AW'(96) && waddr_i < AW'(128)) |-> rdata_o == 32'h0); // R10
endmodule

bind sysctl_regbank sysctl_regbank_chk #(.AW(AW), .KEY(KEY)) u_chk (
   .clk_i, .rst_ni, .wr_i, .waddr_i, .wdata_i, .rdata_o, .led_o, .reset_req_o,
   .lock_w(lock_w), .osc_w(osc_w), .flag0_w(flag0_w), .cnt_w(cnt_w)
);

// File: tb/sysctl_regbank_tb.sv
`timescale 1ns/1ps
module sysctl_regbank_tb;
   localparam int AW = 10;
   localparam logic [15:0] KEY = 16'hA05F;

   logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0;
   logic [AW-1:0] waddr = '0;
   logic [31:0] wdata = '0, rdata;
   logic led, flash0, rreq;
   int nchk = 0, nerr = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sysctl_regbank u_dut (
      .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .waddr_i(waddr), .wdata_i(wdata),
      .rdata_o(rdata), .led_o(led), .flash_at_zero_o(flash0), .reset_req_o(rreq)
   );

   // models
   logic [15:0] m_lock;
   logic [31:0] m_osc, m_aux, m_flg, m_nvf;

   function automatic logic [31:0] exp_lock(logic [15:0] v);
      return {15'h0, v == KEY, v};
   endfunction

   function automatic logic [7:0] exp_tbl(int idx);
      string tag = "GENERIC-MEM";
      if (idx >= 73 && idx <= 83) return tag[idx-73];
      return 8'h00;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_word(int a, logic [31:0] d);
      @(negedge clk);
      wr = 1'b1; waddr = AW'(a); wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd_word(int a, output logic [31:0] d);
      @(negedge clk);
      waddr = AW'(a);
      #1 d = rdata;
   endtask

   task automatic rd_chk(string req, int a, logic [31:0] exp);
      logic [31:0] d;
      rd_word(a, d);
      chk(req, d, exp);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nchk++; nerr++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      logic [31:0] c0, c1, d;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R8 reset state
      rd_chk("R8 osc reset", 2, 32'h01000048);
      rd_chk("R8 aux reset", 7, 32'h0007FEFF);
      rd_chk("R8 sdram reset", 8, 32'h0001112E);
      rd_chk("R8 init reset", 9, 32'h00000112);
      rd_chk("R8 ctrl reset", 3, 32'h0);
      rd_chk("R8 lock reset", 5, 32'h0);
      rd_chk("R8 flags reset", 12, 32'h0);
      chk("R8 led reset", {31'h0, led}, 32'h0);
      chk("R8 flash at zero reset", {31'h0, flash0}, 32'h1);

      // R1 constants and unmapped space
      rd_chk("R1 ident", 0, 32'h411A3001);
      rd_chk("R1 status", 4, 32'h00100000);
      rd_chk("R1 proc", 1, 32'h0);
      wr_word(20, 32'hFFFF_FFFF);
      rd_chk("R1 unmapped word 20", 20, 32'h0);
      wr_word(200, 32'h1234_5678);
      rd_chk("R1 unmapped word 200", 200, 32'h0);
      rd_chk("R1 ident after stray writes", 0, 32'h411A3001);

      // R3 directed: locked write ignored, then unlock and write
      wr_word(2, 32'hDEAD_BEEF);
      rd_chk("R3 osc locked", 2, 32'h01000048);
      wr_word(5, 32'hFFFF_A05F);
      rd_chk("R2 lock key read", 5, 32'h0001A05F);
      wr_word(2, 32'hCAFE_0001);
      rd_chk("R3 osc unlocked", 2, 32'hCAFE_0001);
      wr_word(5, 32'h0000_A05E);
      rd_chk("R2 lock near key", 5, 32'h0000A05E);
      wr_word(7, 32'h1111_2222);
      rd_chk("R3 aux locked", 7, 32'h0007FEFF);

      // R2/R3/R6 random mix
      m_lock = 16'hA05E; m_osc = 32'hCAFE_0001; m_aux = 32'h0007FEFF;
      m_flg = 32'h0; m_nvf = 32'h0;
      for (int i = 0; i < 400; i++) begin
         int op = $urandom_range(0, 7);
         logic [31:0] v = $urandom;
         case (op)
            0: begin
               if (v[0]) v[15:0] = KEY;
               wr_word(5, v); m_lock = v[15:0];
               rd_chk("R2 lock random", 5, exp_lock(m_lock));
            end
            1: begin wr_word(2, v); if (m_lock == KEY) m_osc = v;
                     rd_chk("R3 osc random", 2, m_osc); end
            2: begin wr_word(7, v); if (m_lock == KEY) m_aux = v;
                     rd_chk("R3 aux random", 7, m_aux); end
            3: begin wr_word(12, v); m_flg |= v; rd_chk("R6 flag set", 12, m_flg); end
            4: begin wr_word(13, v); m_flg &= ~v; rd_chk("R6 flag clr", 12, m_flg); end
            5: begin wr_word(14, v); m_nvf |= v; rd_chk("R6 nvflag set", 14, m_nvf); end
            6: begin wr_word(15, v); m_nvf &= ~v; rd_chk("R6 nvflag clr", 14, m_nvf); end
            default: begin
               rd_chk("R6 flag hold", 12, m_flg);
               rd_chk("R6 nvflag hold", 14, m_nvf);
            end
         endcase
      end
      rd_chk("R6 clear word reads zero", 13, 32'h0);
      rd_chk("R6 nv clear word reads zero", 15, 32'h0);

      // R4/R5 control
      @(negedge clk);
      wr = 1'b1; waddr = AW'(3); wdata = 32'hFFFF_FFFF;
      #1 chk("R5 reset pulse during write", {31'h0, rreq}, 32'h1);
      @(negedge clk);
      wr = 1'b0;
      #1 chk("R5 pulse gone after write", {31'h0, rreq}, 32'h0);
      rd_chk("R4 ctrl keeps bits 0 and 2", 3, 32'h5);
      chk("R4 led on", {31'h0, led}, 32'h1);
      chk("R4 flash unmapped", {31'h0, flash0}, 32'h0);
      @(negedge clk);
      wr = 1'b1; waddr = AW'(3); wdata = 32'h0000_0002;
      #1 chk("R5 no pulse without bit 3", {31'h0, rreq}, 32'h0);
      @(negedge clk);
      wr = 1'b0;
      rd_chk("R4 ctrl bit 1 dropped", 3, 32'h0);
      chk("R4 flash back at zero", {31'h0, flash0}, 32'h1);
      @(negedge clk);
      wr = 1'b0; waddr = AW'(3); wdata = 32'h8;
      #1 chk("R5 no pulse without strobe", {31'h0, rreq}, 32'h0);

      // R7
      wr_word(8, 32'h89AB_CDEF);
      rd_chk("R7 sdram write", 8, 32'h89AB_CDEF);
      wr_word(9, 32'h0F0F_F0F0);
      rd_chk("R7 init write", 9, 32'h0F0F_F0F0);

      // R10 table window
      rd_chk("R10 below tag", 72, 32'h0);
      rd_chk("R10 tag first", 73, {24'h0, exp_tbl(73)});
      rd_chk("R10 tag middle", 78, {24'h0, exp_tbl(78)});
      rd_chk("R10 tag last", 83, {24'h0, exp_tbl(83)});
      rd_chk("R10 after tag", 84, 32'h0);
      rd_chk("R10 window start", 64, 32'h0);
      rd_chk("R10 upper half", 96, 32'h0);
      rd_chk("R10 upper half end", 127, 32'h0);
      wr_word(73, 32'hFF);
      rd_chk("R10 window ignores writes", 73, {24'h0, exp_tbl(73)});

      // R9 count rate over 1000 clocks
      rd_word(10, c0);
      repeat (999) @(negedge clk);
      rd_word(10, c1);
      d = c1 - c0;
      nchk++;
      if (d < 32'd480 || d > 32'd480) begin
         nerr++;
         $display("FAIL R9 count delta: actual=%0d expected=480", d);
      end
      rd_word(10, c0);
      repeat (24) @(negedge clk);
      rd_word(10, c1);
      d = c1 - c0;
      nchk++;
      if (d < 32'd12 || d > 32'd13) begin
         nerr++;
         $display("FAIL R9 short delta: actual=%0d expected=12..13", d);
      end

      done = 1'b1;
      finish_run();
   end
endmodule